// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block sits on the device side of a parallel-ATA style disk interface. It holds the task-file registers and sequences the commands the host writes to them. A host port writes bytes to, and reads from, eight register offsets. Offset 0 is a 16-bit data port that delivers the words of a built-in identify image. The block decodes each command, drives a status byte and an interrupt line, and coordinates two external agents: a cache that completes a flush, and a DMA engine that moves sectors.

Host accesses are single-cycle strobes. Read data is combinational from the address and the current state. Any side effect of a read (the data port advancing, the interrupt clearing) takes place at the clock edge that ends the strobe. The host port has no back-pressure. The host must poll the status byte and follow it: it reads data words only while the transfer-request bit is set, and it writes a new command only when neither busy nor transfer-request is set.

The DMA side is a plain start/done handshake. A one-cycle start pulse carries the direction, the 24-bit block address and the transfer length in bytes. The controller then reports busy until the engine strobes done. The flush side works the same way: a request level stays high until the completion strobe arrives.

Top module: `ata_regfile_ctrl`

## Requirements
- R1: After reset, status reads 0x40, the interrupt is low, `flush_req` and `dma_start` are low, and offsets 2 to 6 read 0.
- R2: Offsets 2 (count), 3, 4, 5 (address bytes, low to high) and 6 (device select) read back the last byte written to them, zero-extended to 16 bits. Offset 1 always reads 0.
- R3: Command 0xEC sets status to 0x48 (ready and transfer-request) and raises the interrupt. It stays 0x48 for exactly 256 reads of offset 0. After the 256th read, status is 0x40.
- R4: Identify word n, read as the n-th data-port read, has these values. Word 0 is 0x0040. Words 10 to 19 hold a 20-character serial string and words 23 to 26 hold an 8-character version string, each word with its earlier character in bits 15:8. Words 60 and 61 hold the low and high halves of the 32-bit sector capacity. Word 85 is 0x0020, which reports write caching enabled. All other words are 0.
- R5: A read of offset 0 while status bit 3 is clear returns 0 and does not advance the identify word sequence.
- R6: Command 0xE7 sets status to 0xC0 and raises `flush_req`. Both hold until `flush_done` pulses. Status then returns to 0x40 and the interrupt rises.
- R7: A read of offset 7 lowers the interrupt at the next edge, unless a completion event occurs in the same cycle.
- R8: Commands 0xC8 (device to host, `dma_to_host`=1) and 0xCA (host to device, `dma_to_host`=0) produce a `dma_start` pulse of one cycle in the cycle after the command write. The pulse carries `dma_lba` = {offset 5, offset 4, offset 3} and `dma_bytes` = count × 512, where a count of 0 means 256 sectors. Status is 0xC0 meanwhile.
- R9: A `dma_done` pulse during a DMA command returns status to 0x40 and raises the interrupt.
- R10: Any command code other than 0xEC, 0xE7, 0xC8 and 0xCA sets status to 0x41 and raises the interrupt. The error bit stays set until the next accepted supported command clears it.
- R11: A command write while status bit 7 or bit 3 is set is ignored.
- R12: A command write while device-select bit 4 (0x10) is set is ignored.
- R13: `flush_done` or `dma_done` outside the matching command has no effect on status or the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 16 | Read data for `host_addr` |
| irq | output | 1 | Interrupt request |
| flush_req | output | 1 | Flush in progress |
| flush_done | input | 1 | Flush completion strobe |
| dma_start | output | 1 | One-cycle DMA start pulse |
| dma_to_host | output | 1 | DMA direction, 1 = device to host |
| dma_lba | output | 24 | DMA starting block address |
| dma_bytes | output | 18 | DMA length in bytes |
| dma_done | input | 1 | DMA completion strobe |

## Verification
The bound checker watches, on every cycle, the invariants of the status byte: busy and transfer-request never appear together, error never appears with busy, a flush or DMA wait holds busy until its strobe, a status read clears the interrupt, and the start pulse lasts one cycle. It also counts data-port reads so that transfer-request can fall only after exactly 256 of them. Only the bench scenarios can show the content of the identify image, the byte count and address carried by a DMA start, the classification of every one of the 256 command codes, and the fact that ignored writes and strobes really leave the state untouched.

// File: rtl/ata_regs_pkg.sv
package ata_regs_pkg;

  localparam logic [2:0] OFS_DATA    = 3'd0;
  localparam logic [2:0] OFS_SPARE   = 3'd1;
  localparam logic [2:0] OFS_COUNT   = 3'd2;
  localparam logic [2:0] OFS_ADDR0   = 3'd3;
  localparam logic [2:0] OFS_ADDR1   = 3'd4;
  localparam logic [2:0] OFS_ADDR2   = 3'd5;
  localparam logic [2:0] OFS_DEVSEL  = 3'd6;
  localparam logic [2:0] OFS_STATCMD = 3'd7;

  localparam int STB_BUSY  = 7;
  localparam int STB_READY = 6;
  localparam int STB_FAULT = 5;
  localparam int STB_XFER  = 3;
  localparam int STB_FAIL  = 0;

  localparam int DEVSEL_UNIT_BIT = 4;

  localparam logic [7:0] OP_IDENT   = 8'hEC;
  localparam logic [7:0] OP_FLUSH   = 8'hE7;
  localparam logic [7:0] OP_DMA_IN  = 8'hC8;
  localparam logic [7:0] OP_DMA_OUT = 8'hCA;

  typedef enum logic [1:0] {PH_IDLE, PH_PIO, PH_FLUSH, PH_DMA} phase_e;
  typedef enum logic [2:0] {K_IDENT, K_FLUSH, K_DMA_IN, K_DMA_OUT, K_BAD} cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [7:0] op);
    case (op)
      OP_IDENT:   return K_IDENT;
      OP_FLUSH:   return K_FLUSH;
      OP_DMA_IN:  return K_DMA_IN;
      OP_DMA_OUT: return K_DMA_OUT;
      default:    return K_BAD;
    endcase
  endfunction

endpackage

// File: rtl/ata_ident_image.sv
module ata_ident_image #(
  parameter int          WORDS         = 256,
  parameter int          SERIAL_CHARS  = 20,
  parameter int          VERSION_CHARS = 8,
  parameter logic [8*SERIAL_CHARS-1:0]  SERIAL_STR  = {SERIAL_CHARS{8'h20}},
  parameter logic [8*VERSION_CHARS-1:0] VERSION_STR = {VERSION_CHARS{8'h20}},
  parameter logic [31:0] CAP_SECTORS   = 32'd131072,
  localparam int         IDX_W         = $clog2(WORDS)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [15:0]      word
);
  localparam int SER_W0   = 10;
  localparam int SER_WN   = SERIAL_CHARS / 2;
  localparam int VER_W0   = 23;
  localparam int VER_WN   = VERSION_CHARS / 2;
  localparam int CAP_LO_W = 60;
  localparam int CAP_HI_W = 61;
  localparam int FEAT_W   = 85;
  localparam int TYPE_W   = 0;

  int n;
  int k;

  always_comb begin
    n    = int'(idx);
    k    = 0;
    word = 16'h0000;
    if (n == TYPE_W) begin
      word = 16'h0040;
    end else if (n >= SER_W0 && n < SER_W0 + SER_WN) begin
      k    = n - SER_W0;
      word = {SERIAL_STR[8*(SERIAL_CHARS-1-2*k) +: 8],
              SERIAL_STR[8*(SERIAL_CHARS-2-2*k) +: 8]};
    end else if (n >= VER_W0 && n < VER_W0 + VER_WN) begin
      k    = n - VER_W0;
      word = {VERSION_STR[8*(VERSION_CHARS-1-2*k) +: 8],
              VERSION_STR[8*(VERSION_CHARS-2-2*k) +: 8]};
    end else if (n == CAP_LO_W) begin
      word = CAP_SECTORS[15:0];
    end else if (n == CAP_HI_W) begin
      word = CAP_SECTORS[31:16];
    end else if (n == FEAT_W) begin
      word = 16'h0020;
    end
  end

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_regs_pkg::*;
#(
  parameter int  COUNT_W = 8,
  parameter int  ADDR_BYTES = 3,
  localparam int LBA_W = 8 * ADDR_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         addr,
  input  logic [7:0]         wdata,
  input  logic [7:0]         status,
  input  logic [15:0]        ident_word,
  output logic [COUNT_W-1:0] count,
  output logic [LBA_W-1:0]   lba,
  output logic [7:0]         devsel,
  output logic [15:0]        rdata
);
  logic [7:0] addr_byte [ADDR_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      devsel <= '0;
    end else if (wr_en) begin
      if (addr == OFS_COUNT)  count  <= wdata[COUNT_W-1:0];
      if (addr == OFS_DEVSEL) devsel <= wdata;
    end
  end

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_addr
    always_ff @(posedge clk) begin
      if (!rst_n)
        addr_byte[b] <= '0;
      else if (wr_en && addr == OFS_ADDR0 + 3'(b))
        addr_byte[b] <= wdata;
    end
    assign lba[8*b +: 8] = addr_byte[b];
  end

  always_comb begin
    rdata = 16'h0000;
    case (addr)
      OFS_DATA:    rdata = status[STB_XFER] ? ident_word : 16'h0000;
      OFS_COUNT:   rdata = 16'(count);
      OFS_ADDR0:   rdata = {8'h00, addr_byte[0]};
      OFS_ADDR1:   rdata = {8'h00, addr_byte[1]};
      OFS_ADDR2:   rdata = {8'h00, addr_byte[2]};
      OFS_DEVSEL:  rdata = {8'h00, devsel};
      OFS_STATCMD: rdata = {8'h00, status};
      default:     rdata = 16'h0000;
    endcase
  end

endmodule

// File: rtl/ata_cmd_seq.sv
module ata_cmd_seq
  import ata_regs_pkg::*;
#(
  parameter int  WORDS        = 256,
  parameter int  COUNT_W      = 8,
  parameter int  LBA_W        = 24,
  parameter int  SECTOR_BYTES = 512,
  localparam int IDX_W        = $clog2(WORDS),
  localparam int MAX_SECT     = 1 << COUNT_W,
  localparam int SECT_W       = $clog2(MAX_SECT + 1),
  localparam int BYTES_W      = $clog2(MAX_SECT * SECTOR_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [7:0]         cmd_op,
  input  logic               unit1_sel,
  input  logic               data_rd,
  input  logic               stat_rd,
  input  logic [COUNT_W-1:0] count,
  input  logic [LBA_W-1:0]   lba,
  input  logic               flush_done,
  input  logic               dma_done,
  output logic [7:0]         status,
  output logic [IDX_W-1:0]   word_idx,
  output logic               irq,
  output logic               flush_req,
  output logic               dma_start,
  output logic               dma_to_host,
  output logic [LBA_W-1:0]   dma_lba,
  output logic [BYTES_W-1:0] dma_bytes
);
  phase_e       phase;
  logic         err_q;
  cmd_kind_e    kind;
  logic         accept;
  logic         irq_set;
  logic [SECT_W-1:0]  sectors;
  logic [BYTES_W-1:0] req_bytes;

  assign kind    = classify(cmd_op);
  assign accept  = cmd_wr && (phase == PH_IDLE) && !unit1_sel;
  assign sectors = (count == '0) ? SECT_W'(MAX_SECT) : SECT_W'(count);
  assign req_bytes = BYTES_W'(sectors) * BYTES_W'(SECTOR_BYTES);

  always_comb begin
    irq_set = 1'b0;
    if (accept && (kind == K_IDENT || kind == K_BAD)) irq_set = 1'b1;
    if (phase == PH_FLUSH && flush_done)              irq_set = 1'b1;
    if (phase == PH_DMA && dma_done)                  irq_set = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      err_q       <= 1'b0;
      word_idx    <= '0;
      irq         <= 1'b0;
      dma_start   <= 1'b0;
      dma_to_host <= 1'b0;
      dma_lba     <= '0;
      dma_bytes   <= '0;
    end else begin
      dma_start <= 1'b0;
      if (irq_set)      irq <= 1'b1;
      else if (stat_rd) irq <= 1'b0;
      case (phase)
        PH_IDLE: if (accept) begin
          err_q <= (kind == K_BAD);
          case (kind)
            K_IDENT: begin
              phase    <= PH_PIO;
              word_idx <= '0;
            end
            K_FLUSH: phase <= PH_FLUSH;
            K_DMA_IN, K_DMA_OUT: begin
              phase       <= PH_DMA;
              dma_start   <= 1'b1;
              dma_to_host <= (kind == K_DMA_IN);
              dma_lba     <= lba;
              dma_bytes   <= req_bytes;
            end
            default: phase <= PH_IDLE;
          endcase
        end
        PH_PIO: if (data_rd) begin
          if (word_idx == IDX_W'(WORDS - 1)) begin
            phase    <= PH_IDLE;
            word_idx <= '0;
          end else begin
            word_idx <= word_idx + 1'b1;
          end
        end
        PH_FLUSH: if (flush_done) phase <= PH_IDLE;
        PH_DMA:   if (dma_done)   phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    status            = 8'h00;
    status[STB_BUSY]  = (phase == PH_FLUSH) || (phase == PH_DMA);
    status[STB_READY] = 1'b1;
    status[STB_FAULT] = 1'b0;
    status[STB_XFER]  = (phase == PH_PIO);
    status[STB_FAIL]  = err_q;
  end

  assign flush_req = (phase == PH_FLUSH);

endmodule

// File: rtl/ata_regfile_ctrl.sv
module ata_regfile_ctrl
  import ata_regs_pkg::*;
#(
  parameter int          IDENT_WORDS   = 256,
  parameter int          SECTOR_BYTES  = 512,
  parameter int          SERIAL_CHARS  = 20,
  parameter int          VERSION_CHARS = 8,
  parameter logic [8*SERIAL_CHARS-1:0]  SERIAL_STR  = "BLK-SERIAL-00000001 ",
  parameter logic [8*VERSION_CHARS-1:0] VERSION_STR = "fw-0.1  ",
  parameter logic [31:0] CAP_SECTORS   = 32'd131072,
  localparam int         COUNT_W       = 8,
  localparam int         LBA_W         = 24,
  localparam int         BYTES_W       = $clog2((1 << COUNT_W) * SECTOR_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [2:0]         host_addr,
  input  logic [7:0]         host_wdata,
  output logic [15:0]        host_rdata,
  output logic               irq,
  output logic               flush_req,
  input  logic               flush_done,
  output logic               dma_start,
  output logic               dma_to_host,
  output logic [LBA_W-1:0]   dma_lba,
  output logic [BYTES_W-1:0] dma_bytes,
  input  logic               dma_done
);
  localparam int IDX_W = $clog2(IDENT_WORDS);

  logic [7:0]         stat_byte;
  logic [15:0]        ident_word;
  logic [IDX_W-1:0]   word_idx;
  logic [COUNT_W-1:0] tf_count;
  logic [LBA_W-1:0]   tf_lba;
  logic [7:0]         tf_devsel;

  ata_taskfile #(
    .COUNT_W    (COUNT_W),
    .ADDR_BYTES (LBA_W / 8)
  ) u_tf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (host_wr),
    .addr       (host_addr),
    .wdata      (host_wdata),
    .status     (stat_byte),
    .ident_word (ident_word),
    .count      (tf_count),
    .lba        (tf_lba),
    .devsel     (tf_devsel),
    .rdata      (host_rdata)
  );

  ata_ident_image #(
    .WORDS         (IDENT_WORDS),
    .SERIAL_CHARS  (SERIAL_CHARS),
    .VERSION_CHARS (VERSION_CHARS),
    .SERIAL_STR    (SERIAL_STR),
    .VERSION_STR   (VERSION_STR),
    .CAP_SECTORS   (CAP_SECTORS)
  ) u_img (
    .idx  (word_idx),
    .word (ident_word)
  );

  ata_cmd_seq #(
    .WORDS        (IDENT_WORDS),
    .COUNT_W      (COUNT_W),
    .LBA_W        (LBA_W),
    .SECTOR_BYTES (SECTOR_BYTES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (host_wr && host_addr == OFS_STATCMD),
    .cmd_op      (host_wdata),
    .unit1_sel   (tf_devsel[DEVSEL_UNIT_BIT]),
    .data_rd     (host_rd && host_addr == OFS_DATA),
    .stat_rd     (host_rd && host_addr == OFS_STATCMD),
    .count       (tf_count),
    .lba         (tf_lba),
    .flush_done  (flush_done),
    .dma_done    (dma_done),
    .status      (stat_byte),
    .word_idx    (word_idx),
    .irq         (irq),
    .flush_req   (flush_req),
    .dma_start   (dma_start),
    .dma_to_host (dma_to_host),
    .dma_lba     (dma_lba),
    .dma_bytes   (dma_bytes)
  );

endmodule

// File: rtl/ata_regfile_ctrl_chk.sv
module ata_regfile_ctrl_chk #(
  parameter int WORDS = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_rd,
  input logic [2:0] host_addr,
  input logic [7:0] status,
  input logic       irq,
  input logic       flush_req,
  input logic       flush_done,
  input logic       dma_start,
  input logic       dma_done
);
  localparam int CNT_W = $clog2(WORDS + 1);
  logic [CNT_W-1:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         rd_cnt <= '0;
    else if (!status[3]) rd_cnt <= '0;
    else if (host_rd && host_addr == 3'd0) rd_cnt <= rd_cnt + 1'b1;
  end

  // R3
  drq_bsy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[3]));

  // R3
  ident_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[3]) |-> rd_cnt == CNT_W'(WORDS));

  // R6
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_done |=> flush_req && status[7]);

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == 3'd7 && !host_wr && !flush_done && !dma_done |=> !irq);

  // R8
  dma_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);

  // R8
  dma_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> status[7] && !flush_req);

  // R10
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> !status[7] && !status[3]);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] && !flush_done && !dma_done |=> status[7]);

endmodule

bind ata_regfile_ctrl ata_regfile_ctrl_chk #(.WORDS(IDENT_WORDS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_addr  (host_addr),
  .status     (stat_byte),
  .irq        (irq),
  .flush_req  (flush_req),
  .flush_done (flush_done),
  .dma_start  (dma_start),
  .dma_done   (dma_done)
);

// File: tb/ata_regfile_ctrl_test.sv
`timescale 1ns/1ps
module ata_regfile_ctrl_test;
  localparam logic [159:0] SER = "ZX-0042-LAB-UNIT-A7 ";
  localparam logic [63:0]  VER = "rev1.0b ";
  localparam logic [31:0]  CAP = 32'h0001_2345;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [7:0]  host_wdata = 8'h00;
  logic [15:0] host_rdata;
  logic        irq, flush_req, dma_start, dma_to_host;
  logic        flush_done = 1'b0, dma_done = 1'b0;
  logic [23:0] dma_lba;
  logic [17:0] dma_bytes;

  int vectors = 0;
  int errors  = 0;
  logic [15:0] d;

  always #4 clk = ~clk;

  ata_regfile_ctrl #(
    .SERIAL_STR (SER), .VERSION_STR (VER), .CAP_SECTORS (CAP)
  ) uut (
    .clk (clk), .rst_n (rst_n), .host_wr (host_wr), .host_rd (host_rd),
    .host_addr (host_addr), .host_wdata (host_wdata), .host_rdata (host_rdata),
    .irq (irq), .flush_req (flush_req), .flush_done (flush_done),
    .dma_start (dma_start), .dma_to_host (dma_to_host), .dma_lba (dma_lba),
    .dma_bytes (dma_bytes), .dma_done (dma_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = v;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    #1 v = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush_done = 1'b1;
    @(negedge clk); flush_done = 1'b0;
  endtask

  task automatic pulse_dma();
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
  endtask

  function automatic logic [15:0] ident_exp(input int i);
    int k;
    if (i == 0) return 16'h0040;
    if (i >= 10 && i <= 19) begin
      k = i - 10;
      return {SER[8*(19-2*k) +: 8], SER[8*(18-2*k) +: 8]};
    end
    if (i >= 23 && i <= 26) begin
      k = i - 23;
      return {VER[8*(7-2*k) +: 8], VER[8*(6-2*k) +: 8]};
    end
    if (i == 60) return CAP[15:0];
    if (i == 61) return CAP[31:16];
    if (i == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 flush_req", 32'(flush_req), 0);
    chk("R1 dma_start", 32'(dma_start), 0);
    rd(3'd7, d); chk("R1 status", 32'(d), 32'h40);
    for (int a = 2; a <= 6; a++) begin
      rd(3'(a), d); chk("R1 reg", 32'(d), 0);
    end

    // R2 register readback sweep
    for (int p = 0; p < 4; p++) begin
      for (int a = 2; a <= 6; a++) wr(3'(a), 8'(p * 8'h5b + a * 8'h11) & 8'hEF);
      for (int a = 2; a <= 6; a++) begin
        rd(3'(a), d); chk("R2 readback", 32'(d), 32'((p * 8'h5b + a * 8'h11) & 8'hEF));
      end
      rd(3'd1, d); chk("R2 offset1", 32'(d), 0);
    end

    // R5 data port idle read
    rd(3'd0, d); chk("R5 idle data", 32'(d), 0);
    rd(3'd0, d); chk("R5 idle data", 32'(d), 0);

    // R12 device 1 selected: command ignored
    wr(3'd6, 8'h50);
    wr(3'd7, 8'hEC);
    chk("R12 irq", 32'(irq), 0);
    rd(3'd7, d); chk("R12 status", 32'(d), 32'h40);
    rd(3'd6, d); chk("R12 devsel", 32'(d), 32'h50);
    wr(3'd6, 8'h40);

    // R3/R4 identify sweep
    wr(3'd7, 8'hEC);
    chk("R3 irq", 32'(irq), 1);
    rd(3'd6, d); chk("R3 dev bit4", 32'(d[4]), 0);
    for (int i = 0; i < 256; i++) begin
      rd(3'd7, d); chk("R3 status drq", 32'(d), 32'h48);
      if (i == 100) begin
        wr(3'd7, 8'hE7);  // R11 ignored during DRQ
        chk("R11 flush_req", 32'(flush_req), 0);
        rd(3'd7, d); chk("R11 status", 32'(d), 32'h48);
      end
      rd(3'd0, d); chk("R4 word", 32'(d), 32'(ident_exp(i)));
    end
    rd(3'd7, d); chk("R3 status end", 32'(d), 32'h40);
    rd(3'd0, d); chk("R5 after drq", 32'(d), 0);

    // R6 flush with R11 busy ignore
    wr(3'd7, 8'hE7);
    chk("R6 flush_req", 32'(flush_req), 1);
    rd(3'd7, d); chk("R6 status busy", 32'(d), 32'hC0);
    repeat (5) @(negedge clk);
    chk("R6 irq hold", 32'(irq), 0);
    wr(3'd7, 8'hC8);
    chk("R11 dma_start", 32'(dma_start), 0);
    rd(3'd7, d); chk("R6 status held", 32'(d), 32'hC0);
    pulse_flush();
    chk("R6 irq", 32'(irq), 1);
    chk("R6 flush_req low", 32'(flush_req), 0);
    rd(3'd7, d); chk("R6 status done", 32'(d), 32'h40);
    chk("R7 irq cleared", 32'(irq), 0);

    // R13 stray strobes
    pulse_flush();
    pulse_dma();
    chk("R13 irq", 32'(irq), 0);
    rd(3'd7, d); chk("R13 status", 32'(d), 32'h40);

    // R8/R9 DMA sweep
    for (int t = 0; t < 8; t++) begin
      logic [7:0]  cnt;
      logic [23:0] lba;
      logic [7:0]  op;
      cnt = (t == 0) ? 8'd0 : (t == 1) ? 8'd1 : (t == 2) ? 8'd255 : 8'(t * 37);
      lba = 24'(t * 24'h13579B + 24'h0A0B0C);
      op  = t[0] ? 8'hCA : 8'hC8;
      wr(3'd2, cnt);
      wr(3'd3, lba[7:0]); wr(3'd4, lba[15:8]); wr(3'd5, lba[23:16]);
      wr(3'd7, op);
      chk("R8 start", 32'(dma_start), 1);
      chk("R8 dir", 32'(dma_to_host), 32'(op == 8'hC8));
      chk("R8 lba", 32'(dma_lba), 32'(lba));
      chk("R8 bytes", 32'(dma_bytes), 32'(((cnt == 0) ? 256 : int'(cnt)) * 512));
      @(negedge clk);
      chk("R8 pulse end", 32'(dma_start), 0);
      rd(3'd7, d); chk("R8 status", 32'(d), 32'hC0);
      pulse_dma();
      chk("R9 irq", 32'(irq), 1);
      rd(3'd7, d); chk("R9 status", 32'(d), 32'h40);
    end

    // R10 all command codes
    for (int c = 0; c < 256; c++) begin
      if (c != 8'hEC && c != 8'hE7 && c != 8'hC8 && c != 8'hCA) begin
        wr(3'd7, 8'(c));
        chk("R10 irq", 32'(irq), 1);
        chk("R10 no start", 32'(dma_start | flush_req), 0);
        rd(3'd7, d); chk("R10 status", 32'(d), 32'h41);
      end
    end
    wr(3'd7, 8'hE7);
    rd(3'd7, d); chk("R10 err cleared", 32'(d), 32'hC0);
    pulse_flush();
    rd(3'd7, d); chk("R10 final", 32'(d), 32'h40);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule